// File: doc/BRIEF.md
# Multi-Select External Peripheral Bus Controller

This block connects a single-clock internal request port to an asynchronous-style peripheral bus. The peripheral bus has a 24-bit address, a 16-bit data path and eight active-low chip selects. Bits [27:24] of the internal address pick one of sixteen 16 MB windows. Windows 0 to 7 belong to chip selects 0 to 7. Windows 8 to 15 select no device.

Each chip select has its own configuration word, written and read through a small register port. The word holds the following settings:
- an enable bit
- the data width (8 or 16 bits)
- the strobe style: separate read and write strobes, or one data strobe with a read/not-write level
- multiplexed or separate address/data
- four phase lengths
- a window size

Chip select 0 comes out of reset enabled with the slowest timing, ready to fetch from a boot flash. A strap pin, sampled as reset is released, sets the size of its window. The other seven selects stay off until software programs them.

An internal access becomes one or two bus cycles. Each bus cycle runs through four phases in order: setup, strobe, hold and recovery. The controller answers with a one-cycle response that carries read data or an error flag.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, configuration word 0 reads 0x007FFFF3 or 0x008FFFF3. Bit 0 is enable, bit 1 is 16-bit width, bit 2 is strobe-and-direction style, bit 3 is multiplexed, [7:4] is setup, [11:8] is strobe, [15:12] is hold, [19:16] is recovery and [23:20] is the size code. Words 1 to 7 read zero.
- R2: The CS0 size code is 8 (16 MB) when `strap_a0` is high in the last reset cycle and 7 (8 MB) when it is low. The size code s opens a window of 64 KB << s, and codes above 8 count as 16 MB.
- R3: An access returns a response with `rsp_err` high one cycle after acceptance, and no chip select, strobe or driven data appears, when any of these holds: the window index is 8 or above, the select is disabled, the offset lies outside the window, or `req_be` is 00.
- R4: Each phase lasts its 4-bit count plus one cycles. The order is setup, strobe, hold, recovery. The chip select and address are active during the first three phases only. The response comes in the cycle after the last recovery cycle.
- R5: With bit 2 clear, `ext_rd_n` (read) or `ext_wr_n` (write) is low during the strobe phase. `ext_ds_n` stays high and `ext_rnw` stays high.
- R6: With bit 2 set, `ext_ds_n` is low during the strobe phase. `ext_rnw` is low through setup, strobe and hold of a write. `ext_rd_n` and `ext_wr_n` stay high.
- R7: With bit 3 set, `ext_ale` is high and the address bits [15:0] are driven on `ext_dout` during setup. With bit 3 clear, `ext_ale` stays low and the data lines are not driven in setup.
- R8: On an 8-bit select, each enabled byte becomes its own full bus cycle, low byte first. Address bit 0 carries the byte index. Write bytes go out on `ext_dout[7:0]`. Read bytes come from `ext_din[7:0]` into their lane, and disabled lanes return zero.
- R9: On a 16-bit select, one bus cycle runs with address bit 0 forced to 0. The whole 16-bit word is written, or a read returns the whole `ext_din` word.
- R10: The configuration of an access is captured at acceptance. A register write during the access does not change it. The next access uses the new value.
- R11: At most one chip select is low at a time. `req_ready` is high only while no access or response is in progress.
- R12: Configuration bits [31:24] are not stored and always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_a0 | input | 1 | Boot size strap, sampled while reset is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Selected configuration word |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Internal byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle response |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 16 | Read data with response |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 24 | Peripheral address |
| ext_dout | output | 16 | Data or multiplexed address out |
| ext_doe | output | 1 | Data output enable |
| ext_din | input | 16 | Data in from peripheral |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, separate-strobe style |
| ext_wr_n | output | 1 | Write strobe, separate-strobe style |
| ext_ds_n | output | 1 | Data strobe, strobe-and-direction style |
| ext_rnw | output | 1 | Read/not-write level |

## Verification
Most internal faults show on the pins within one or two cycles:
- A wrong phase counter shifts a strobe edge by at least one cycle.
- A wrong byte or pending flag adds or drops a whole bus cycle.
- A wrong captured mode flips the strobe pins in the very next strobe phase.

The bench predicts every pin in every cycle from its own model of the requirements and compares them. A timing or sequencing slip is therefore caught in the cycle it first appears.

Configuration faults show either at once on the register read port, or at the first access that uses the bad field. This covers a strap value that was not captured, or a mask on the spare bits that is missing. A decode fault shows as a missing or spurious error response in the cycle after acceptance.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    localparam int N_CS    = 8;
    localparam int IADDR_W = 28;
    localparam int EADDR_W = 24;
    localparam int DATA_W  = 16;
    localparam int TCNT_W  = 4;
    localparam int WIN_W   = IADDR_W - EADDR_W;
    localparam int MIN_WIN_LOG = 16;

    typedef struct packed {
        logic [7:0]        spare;
        logic [3:0]        size;
        logic [TCNT_W-1:0] t_recov;
        logic [TCNT_W-1:0] t_hold;
        logic [TCNT_W-1:0] t_strobe;
        logic [TCNT_W-1:0] t_setup;
        logic              mux;
        logic              moto;
        logic              wide;
        logic              en;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);

    typedef struct packed {
        logic [TCNT_W-1:0] t_recov;
        logic [TCNT_W-1:0] t_hold;
        logic [TCNT_W-1:0] t_strobe;
        logic [TCNT_W-1:0] t_setup;
        logic              mux;
        logic              moto;
        logic              wide;
    } xfer_mode_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV, PH_RESP, PH_ERR
    } phase_e;

    function automatic cs_cfg_t boot_cfg(input logic strap);
        cs_cfg_t r;
        r          = '0;
        r.en       = 1'b1;
        r.wide     = 1'b1;
        r.t_setup  = '1;
        r.t_strobe = '1;
        r.t_hold   = '1;
        r.t_recov  = '1;
        r.size     = strap ? 4'd8 : 4'd7;
        return r;
    endfunction

    function automatic cs_cfg_t mask_cfg(input logic [CFG_W-1:0] w);
        cs_cfg_t r;
        r       = cs_cfg_t'(w);
        r.spare = '0;
        return r;
    endfunction

    function automatic logic in_window(input logic [3:0] size, input logic [EADDR_W-1:0] off);
        if (size >= 4'd8) return 1'b1;
        return (off >> (MIN_WIN_LOG + int'(size))) == '0;
    endfunction
endpackage

// File: rtl/xbus_cfg_regs.sv
`timescale 1ns/1ps
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int N = N_CS,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output cs_cfg_t          cfg_o [N]
);
    cs_cfg_t cfg_q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= (g == 0) ? boot_cfg(strap_i) : '0;
            end else if (we_i && sel_i == SEL_W'(g)) begin
                cfg_q[g] <= mask_cfg(wdata_i);
            end
        end
        assign cfg_o[g] = cfg_q[g];
    end

    assign rdata_o = cfg_q[sel_i];

    AST_BOOT_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q[0].en && cfg_q[0].t_setup == '1 && !cfg_q[1].en)); // R1
    AST_STRAP_SIZE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q[0].size == ($past(strap_i) ? 4'd8 : 4'd7))); // R2
endmodule

// File: rtl/xbus_decode.sv
`timescale 1ns/1ps
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int N = N_CS,
    localparam int SEL_W = $clog2(N)
) (
    input  logic [IADDR_W-1:0] addr_i,
    input  logic [1:0]         be_i,
    input  cs_cfg_t            cfg_i [N],
    output logic [SEL_W-1:0]   hit_o,
    output xfer_mode_t         mode_o,
    output logic               bad_o
);
    logic [WIN_W-1:0] win;
    logic             in_range;
    cs_cfg_t          sel_cfg;
    logic             unused_spare;

    assign win      = addr_i[IADDR_W-1 -: WIN_W];
    assign in_range = int'(win) < N;
    assign hit_o    = win[SEL_W-1:0];
    assign sel_cfg  = in_range ? cfg_i[hit_o] : '0;
    assign unused_spare = ^sel_cfg.spare;

    always_comb begin
        mode_o.t_recov  = sel_cfg.t_recov;
        mode_o.t_hold   = sel_cfg.t_hold;
        mode_o.t_strobe = sel_cfg.t_strobe;
        mode_o.t_setup  = sel_cfg.t_setup;
        mode_o.mux      = sel_cfg.mux;
        mode_o.moto     = sel_cfg.moto;
        mode_o.wide     = sel_cfg.wide;
    end

    assign bad_o = !in_range || !sel_cfg.en || (be_i == 2'b00)
                 || !in_window(sel_cfg.size, addr_i[EADDR_W-1:0]);
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int N = N_CS,
    localparam int SEL_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_i,
    input  logic               bad_i,
    input  logic [SEL_W-1:0]   hit_i,
    input  xfer_mode_t         mode_i,
    input  logic               write_i,
    input  logic [EADDR_W-1:1] addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [1:0]         be_i,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               idle_o,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [N-1:0]       ext_cs_n,
    output logic [EADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    output logic               ext_ale,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic               ext_ds_n,
    output logic               ext_rnw
);
    phase_e              ph;
    xfer_mode_t          m_q;
    logic [SEL_W-1:0]    hit_q;
    logic                wr_q, byte_q, pend_q;
    logic [EADDR_W-1:1]  addr_q;
    logic [DATA_W-1:0]   wd_q, rd_q;
    logic [TCNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
            m_q <= '0; hit_q <= '0; wr_q <= 1'b0; byte_q <= 1'b0; pend_q <= 1'b0;
            addr_q <= '0; wd_q <= '0; rd_q <= '0; cnt_q <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (acc_i) begin
                    if (bad_i) begin
                        ph <= PH_ERR;
                    end else begin
                        ph     <= PH_SETUP;
                        m_q    <= mode_i;
                        hit_q  <= hit_i;
                        wr_q   <= write_i;
                        addr_q <= addr_i;
                        wd_q   <= wdata_i;
                        rd_q   <= '0;
                        cnt_q  <= mode_i.t_setup;
                        byte_q <= !mode_i.wide && !be_i[0];
                        pend_q <= !mode_i.wide && be_i[0] && be_i[1];
                    end
                end
                PH_SETUP: if (cnt_q == '0) begin
                    ph <= PH_STROBE; cnt_q <= m_q.t_strobe;
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (cnt_q == '0) begin
                    ph <= PH_HOLD; cnt_q <= m_q.t_hold;
                    if (!wr_q) begin
                        if (m_q.wide)    rd_q        <= ext_din;
                        else if (byte_q) rd_q[15:8]  <= ext_din[7:0];
                        else             rd_q[7:0]   <= ext_din[7:0];
                    end
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (cnt_q == '0) begin
                    ph <= PH_RECOV; cnt_q <= m_q.t_recov;
                end else cnt_q <= cnt_q - 1'b1;
                PH_RECOV: if (cnt_q == '0) begin
                    if (pend_q) begin
                        ph <= PH_SETUP; cnt_q <= m_q.t_setup;
                        byte_q <= 1'b1; pend_q <= 1'b0;
                    end else ph <= PH_RESP;
                end else cnt_q <= cnt_q - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    logic              active, strb, data_ph;
    logic [7:0]        wbyte;
    logic [DATA_W-1:0] wval;

    assign active  = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign strb    = (ph == PH_STROBE);
    assign data_ph = ((ph == PH_STROBE) || (ph == PH_HOLD)) && wr_q;
    assign wbyte   = byte_q ? wd_q[15:8] : wd_q[7:0];
    assign wval    = m_q.wide ? wd_q : {8'h00, wbyte};

    assign idle_o    = (ph == PH_IDLE);
    assign rsp_valid = (ph == PH_RESP) || (ph == PH_ERR);
    assign rsp_err   = (ph == PH_ERR);
    assign rsp_rdata = (ph == PH_RESP) ? rd_q : '0;
    assign ext_cs_n  = active ? ~(N'(1) << hit_q) : '1;
    assign ext_addr  = active ? {addr_q, (m_q.wide ? 1'b0 : byte_q)} : '0;
    assign ext_ale   = (ph == PH_SETUP) && m_q.mux;
    assign ext_dout  = ext_ale ? ext_addr[DATA_W-1:0] : (data_ph ? wval : '0);
    assign ext_doe   = ext_ale || data_ph;
    assign ext_rd_n  = !(strb && !m_q.moto && !wr_q);
    assign ext_wr_n  = !(strb && !m_q.moto && wr_q);
    assign ext_ds_n  = !(strb && m_q.moto);
    assign ext_rnw   = !(active && m_q.moto && wr_q);

    logic strobe_on;
    assign strobe_on = !ext_rd_n || !ext_wr_n || !ext_ds_n;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_cs_n)); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (&ext_cs_n && !ext_doe && !strobe_on)); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (strobe_on && $past(strobe_on)) |-> $stable(ext_addr)); // R4
    AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_ale) |-> strobe_on); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(m_q)); // R10
endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int N = N_CS,
    localparam int SEL_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_a0,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [IADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [1:0]         req_be,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [N-1:0]       ext_cs_n,
    output logic [EADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               ext_ale,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic               ext_ds_n,
    output logic               ext_rnw
);
    cs_cfg_t          cfg [N];
    logic [SEL_W-1:0] hit;
    xfer_mode_t       mode;
    logic             bad, idle, unused_a0;

    assign unused_a0 = req_addr[0];

    xbus_cfg_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst), .strap_i(strap_a0), .we_i(cfg_we), .sel_i(cfg_sel),
        .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .cfg_o(cfg)
    );

    xbus_decode #(.N(N)) u_dec (
        .addr_i(req_addr), .be_i(req_be), .cfg_i(cfg),
        .hit_o(hit), .mode_o(mode), .bad_o(bad)
    );

    xbus_seq #(.N(N)) u_seq (
        .clk(clk), .rst(rst), .acc_i(req_valid && idle), .bad_i(bad), .hit_i(hit),
        .mode_i(mode), .write_i(req_write), .addr_i(req_addr[EADDR_W-1:1]),
        .wdata_i(req_wdata), .be_i(req_be), .ext_din(ext_din), .idle_o(idle),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_ds_n(ext_ds_n), .ext_rnw(ext_rnw)
    );

    assign req_ready = idle;

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&ext_cs_n && !rsp_valid)); // R11
endmodule

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, strap = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [15:0] req_wdata = '0, rsp_rdata, ext_dout, ext_din;
    logic [1:0] req_be = '0;
    logic rsp_valid, rsp_err, ext_doe, ext_ale, ext_rd_n, ext_wr_n, ext_ds_n, ext_rnw;
    logic [7:0] ext_cs_n;
    logic [23:0] ext_addr;

    xbus_ctrl dut_i (
        .clk(clk), .rst(rst), .strap_a0(strap), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ext_cs_n(ext_cs_n), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din), .ext_ale(ext_ale),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_ds_n(ext_ds_n), .ext_rnw(ext_rnw)
    );

    function automatic logic [15:0] din_of(input logic [23:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
    endfunction
    assign ext_din = din_of(ext_addr);

    typedef struct {
        logic [7:0] cs_n;
        logic rd_n, wr_n, ds_n, rnw, ale, doe, ready, rv, rerr;
        logic [23:0] addr;
        logic [15:0] dout, rdata;
        string tag;
    } rec_t;

    rec_t q[$];
    logic [31:0] sh [8];
    int errs = 0, checks = 0;
    bit done = 1'b0;

    function automatic rec_t idle_rec(input string t);
        rec_t r;
        r.cs_n = '1; r.rd_n = 1; r.wr_n = 1; r.ds_n = 1; r.rnw = 1; r.ale = 0; r.doe = 0;
        r.ready = 1; r.rv = 0; r.rerr = 0; r.addr = '0; r.dout = '0; r.rdata = '0; r.tag = t;
        return r;
    endfunction

    function automatic logic [72:0] pk(input rec_t r);
        return {r.cs_n, r.rd_n, r.wr_n, r.ds_n, r.rnw, r.ale, r.doe, r.ready, r.rv, r.rerr,
                r.addr, r.dout, (r.rv ? r.rdata : 16'h0)};
    endfunction

    task automatic check(input string tag, input logic [72:0] act, input logic [72:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        rec_t e, a;
        @(negedge clk);
        if (!rst) begin
            e = (q.size() != 0) ? q.pop_front() : idle_rec("R11");
            a.cs_n = ext_cs_n; a.rd_n = ext_rd_n; a.wr_n = ext_wr_n; a.ds_n = ext_ds_n;
            a.rnw = ext_rnw; a.ale = ext_ale; a.doe = ext_doe; a.ready = req_ready;
            a.rv = rsp_valid; a.rerr = rsp_err; a.addr = ext_addr;
            a.dout = ext_dout; a.rdata = rsp_rdata; a.tag = "";
            check(e.tag, pk(a), pk(e));
            check("R11", 73'($countones(~ext_cs_n) <= 1), 73'(1));
        end
    endtask

    task automatic push_access(input logic w, input logic [27:0] a, input logic [15:0] wd,
                               input logic [1:0] be, input string tag);
        int idx, sz, first, last, n;
        logic [31:0] c;
        logic bad;
        logic [15:0] rd, wv;
        logic [23:0] ea;
        rec_t r;
        idx = int'(a[27:24]);
        c = (idx < 8) ? sh[idx] : 32'h0;
        sz = int'(c[23:20]); if (sz > 8) sz = 8;
        bad = (idx >= 8) || !c[0] || (be == 2'b00) || (sz < 8 && (a[23:0] >> (16 + sz)) != 0);
        if (bad) begin
            r = idle_rec(tag); r.ready = 0; r.rv = 1; r.rerr = 1;
            q.push_back(r);
            return;
        end
        rd = '0;
        first = c[1] ? 0 : (be[0] ? 0 : 1);
        last  = c[1] ? 0 : (be[1] ? 1 : 0);
        for (int b = first; b <= last; b++) begin
            ea = c[1] ? {a[23:1], 1'b0} : {a[23:1], b[0]};
            wv = c[1] ? wd : (b == 1 ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]});
            for (int p = 0; p < 4; p++) begin
                n = int'(c[4*p+4 +: 4]) + 1;
                for (int k = 0; k < n; k++) begin
                    r = idle_rec(tag); r.ready = 0;
                    if (p < 3) begin
                        r.cs_n = ~(8'b1 << idx); r.addr = ea;
                        r.rnw = c[2] ? !w : 1'b1;
                    end
                    if (p == 0 && c[3]) begin r.ale = 1; r.dout = ea[15:0]; r.doe = 1; end
                    if (p == 1) begin
                        r.rd_n = !(!c[2] && !w); r.wr_n = !(!c[2] && w); r.ds_n = !c[2];
                    end
                    if ((p == 1 || p == 2) && w) begin r.dout = wv; r.doe = 1; end
                    q.push_back(r);
                end
            end
            if (!w) begin
                if (c[1]) rd = din_of(ea);
                else if (b == 0) rd[7:0] = din_of(ea)[7:0];
                else rd[15:8] = din_of(ea)[7:0];
            end
        end
        r = idle_rec(tag); r.ready = 0; r.rv = 1; r.rdata = rd;
        q.push_back(r);
    endtask

    task automatic drain();
        while (q.size() != 0) tick();
    endtask

    task automatic issue(input logic w, input logic [27:0] a, input logic [15:0] wd,
                         input logic [1:0] be, input string tag);
        drain(); tick();
        req_write = w; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
        push_access(w, a, wd, be, tag);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input int s, input logic [31:0] v);
        cfg_sel = 3'(s); cfg_wdata = v; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        sh[s] = v & 32'h00FF_FFFF;
    endtask

    task automatic cfg_check(input int s, input string tag);
        cfg_sel = 3'(s);
        tick();
        check(tag, 73'(cfg_rdata), 73'(sh[s]));
    endtask

    task automatic do_reset(input logic s);
        rst = 1'b1; strap = s; q.delete();
        repeat (3) tick();
        rst = 1'b0;
        for (int i = 0; i < 8; i++) sh[i] = '0;
        sh[0] = s ? 32'h008F_FFF3 : 32'h007F_FFF3;
        tick();
    endtask

    initial begin
        do_reset(1'b0);
        // R1 R2: reset image, small strap
        for (int i = 0; i < 8; i++) cfg_check(i, "R1");
        cfg_check(0, "R2");
        issue(0, 28'h0900000, 16'h0, 2'b11, "R2");           // outside 8 MB window
        // R4 R5 R9: boot select, slow timing
        issue(0, 28'h0000102, 16'h0, 2'b11, "R9");
        issue(1, 28'h0000340, 16'hBEEF, 2'b01, "R5");
        // R8: byte-wide select, separate strobes
        cfg_write(1, 32'h0081_0211);
        cfg_check(1, "R8");
        issue(1, 28'h1000020, 16'hA55A, 2'b11, "R8");
        issue(0, 28'h1000031, 16'h0, 2'b10, "R8");
        issue(0, 28'h1000044, 16'h0, 2'b11, "R4");
        // R6 R7: wide, strobe-and-direction, multiplexed
        cfg_write(2, 32'h0080_110F);
        issue(1, 28'h2001234, 16'h1357, 2'b11, "R6");
        issue(0, 28'h2005678, 16'h0, 2'b11, "R7");
        // R7 R8: byte-wide multiplexed read
        cfg_write(3, 32'h0082_001D);
        issue(0, 28'h300ABCE, 16'h0, 2'b11, "R7");
        issue(1, 28'h3000010, 16'hC3E1, 2'b11, "R6");
        // R3: error cases
        issue(0, 28'h9000000, 16'h0, 2'b11, "R3");
        issue(1, 28'h4000010, 16'h1, 2'b11, "R3");
        cfg_write(5, 32'h0000_0003);
        issue(0, 28'h5010000, 16'h0, 2'b11, "R3");
        issue(0, 28'h500FFF2, 16'h0, 2'b11, "R3");
        issue(0, 28'h0000004, 16'h0, 2'b00, "R3");
        // R10: reprogram during an access
        issue(0, 28'h2000100, 16'h0, 2'b11, "R10");
        cfg_write(2, 32'h0082_2203);
        drain();
        issue(0, 28'h2000200, 16'h0, 2'b11, "R10");
        // R12: spare bits, oversize code
        cfg_write(6, 32'hFFFF_FFFF);
        cfg_check(6, "R12");
        issue(0, 28'h6FFFFFE, 16'h0, 2'b11, "R12");
        cfg_write(6, 32'h0);
        // R1 R2: reset with strap high
        drain(); tick();
        do_reset(1'b1);
        cfg_check(0, "R2");
        cfg_check(1, "R1");
        issue(0, 28'h0F00000, 16'h0, 2'b11, "R2");
        drain();
        repeat (3) tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule